// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in in pure combinational logic. The operands are split into four 4-bit groups. Inside each group, every bit forms its own generate (a AND b) and propagate (a OR b) signal. A lookahead stage expands the carries into that group's bits as flat sum-of-products terms, and it also forms a group propagate and a group generate. A second lookahead stage of the same shape takes the four group propagate/generate pairs and the carry-in and produces the carry into every group at once. No carry ripples from one group to the next.

The adder brings out the sum, the carry-out, the four group propagate/generate pairs, and one block-level propagate/generate pair. The block-level pair is built from the group pairs in the same way that the group pairs are built from the bits. A parent lookahead stage can therefore treat this adder as one digit of a wider adder. Subtraction and status flags are not part of this block.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + carry_i`, where the operands are unsigned and `carry_i` has weight 1.
- R2: `carry_o` equals bit 16 of `a_i + b_i + carry_i`.
- R3: Within a group, each carry equals g OR (p AND the previous carry), where g = a AND b and p = a OR b for the bit below it. This holds even though the carries are computed as flat products.
- R4: `grp_prop_o[k]` is 1 exactly when, for every bit of operand bits 4k..4k+3, a OR b is 1. Group 0 is bits 0–3 and group 3 is bits 12–15.
- R5: `grp_gen_o[k]` is 1 exactly when adding the 4-bit slices of bits 4k..4k+3 with no carry-in produces a carry out of that slice.
- R6: `blk_gen_o` is 1 exactly when `a_i + b_i` with no carry-in overflows 16 bits.
- R7: `blk_prop_o` is 1 exactly when `a_i | b_i` is all ones.
- R8: `carry_o` equals `blk_gen_o | (blk_prop_o & carry_i)`. Each group's own top carry obeys the same relation with that group's propagate, generate and carry-in.
- R9: A carry-in that reaches a fully propagating run crosses every group boundary in the same evaluation. For example, 0xFFFF + 0x0000 + 1 gives a sum of 0x0000 with a carry-out of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum |
| carry_o | output | 1 | Carry out of bit 15 |
| grp_prop_o | output | 4 | Propagate of each 4-bit group, bit k for bits 4k..4k+3 |
| grp_gen_o | output | 4 | Generate of each 4-bit group |
| blk_prop_o | output | 1 | Propagate of the whole 16-bit block |
| blk_gen_o | output | 1 | Generate of the whole 16-bit block |

## Verification
The bench targets carries that must cross group boundaries: all-ones plus one, alternating patterns that become all ones, and 0x0FFF + 1. A design whose second level drops a product term, or that wires the wrong group carry into a group, gets the upper nibbles of these sums wrong. Two sweeps put dense operand values on the low byte and on the boundary between groups 1 and 2, with the carry-in toggled. In each case the group and block propagate/generate outputs are compared against nibble-wise arithmetic. A propagate built with XOR instead of OR, or a generate that leaves out the carry-in-independent terms, shows up as a wrong `grp_prop_o` or `blk_gen_o`, even when the sum is still correct.

// File: rtl/cla_pkg.sv
// Package: shared sizes for the two-level lookahead adder.
// Assumes the data width is an exact multiple of the group width.
package cla_pkg;
    parameter int GRP_W  = 4;
    parameter int N_GRP  = 4;
    parameter int DATA_W = GRP_W * N_GRP;
endpackage

// File: rtl/cla_pg_bits.sv
// Module: per-bit generate (a AND b) and propagate (a OR b) for a slice.
// Assumes nothing beyond equal-width operands.
module cla_pg_bits #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // one generate/propagate pair per bit position
            assign gen_o[i]  = a_i[i] & b_i[i];
            assign prop_o[i] = a_i[i] | b_i[i];
        end
    endgenerate
endmodule

// File: rtl/cla_lookahead.sv
// Module: lookahead unit. Expands every carry as a flat sum of products over
// W generate/propagate pairs and a carry-in, and forms the combined P and G.
// Used both inside a group (bit level) and across groups (second level).
// Assumes W is small (flat expansion grows as W squared).
module cla_lookahead #(
    parameter int W = 4
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o,
    output logic         grp_prop_o,
    output logic         grp_gen_o
);
    // flat sum-of-products carry expansion
    always_comb begin
        logic acc;
        logic prod;
        carry_o[0] = cin_i;
        for (int j = 0; j < W; j++) begin
            acc = 1'b0;
            for (int k = 0; k <= j; k++) begin
                prod = gen_i[k];
                for (int m = k + 1; m <= j; m++) prod = prod & prop_i[m];
                acc = acc | prod;
            end
            prod = cin_i;
            for (int m = 0; m <= j; m++) prod = prod & prop_i[m];
            carry_o[j+1] = acc | prod;
        end
    end

    // combined propagate and generate, carry-in independent
    always_comb begin
        logic accg;
        logic prodg;
        accg = 1'b0;
        for (int k = 0; k < W; k++) begin
            prodg = gen_i[k];
            for (int m = k + 1; m < W; m++) prodg = prodg & prop_i[m];
            accg = accg | prodg;
        end
        grp_gen_o  = accg;
        grp_prop_o = &prop_i;
    end

    // flat carries must agree with the one-step recurrence
    always_comb begin
        for (int j = 0; j < W; j++) begin
            AST_CARRY_RECURRENCE: assert (carry_o[j+1] == (gen_i[j] | (prop_i[j] & carry_o[j]))); // R3
        end
        AST_TOP_CARRY_PG: assert (carry_o[W] == (grp_gen_o | (grp_prop_o & cin_i))); // R8
    end
endmodule

// File: rtl/cla_group.sv
// Module: one carry-lookahead group. Bit pg, local lookahead, and sum bits.
// Assumes its carry-in arrives from the second-level lookahead.
module cla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         grp_prop_o,
    output logic         grp_gen_o
);
    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W:0]   carries;

    cla_pg_bits #(.W(W)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (bit_gen),
        .prop_o (bit_prop)
    );

    cla_lookahead #(.W(W)) u_la (
        .gen_i      (bit_gen),
        .prop_i     (bit_prop),
        .cin_i      (cin_i),
        .carry_o    (carries),
        .grp_prop_o (grp_prop_o),
        .grp_gen_o  (grp_gen_o)
    );

    // sum bit from operands and the lookahead carry into that bit
    assign sum_o = a_i ^ b_i ^ carries[W-1:0];

    // group result must match arithmetic on the slice
    always_comb begin
        AST_GROUP_SUM: assert ({carries[W], sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i})); // R1
    end
endmodule

// File: rtl/cla_adder16.sv
// Module: two-level carry-lookahead adder. N_GRP groups of GRP_W bits each;
// a second lookahead level supplies every group carry-in directly.
// Purely combinational; block P/G allow a further lookahead level above.
module cla_adder16
    import cla_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic [N_GRP-1:0]  grp_prop_o,
    output logic [N_GRP-1:0]  grp_gen_o,
    output logic              blk_prop_o,
    output logic              blk_gen_o
);
    logic [N_GRP:0] grp_carry;

    genvar k;
    generate
        for (k = 0; k < N_GRP; k++) begin : g_grp
            cla_group #(.W(GRP_W)) u_grp (
                .a_i        (a_i[k*GRP_W +: GRP_W]),
                .b_i        (b_i[k*GRP_W +: GRP_W]),
                .cin_i      (grp_carry[k]),
                .sum_o      (sum_o[k*GRP_W +: GRP_W]),
                .grp_prop_o (grp_prop_o[k]),
                .grp_gen_o  (grp_gen_o[k])
            );
        end
    endgenerate

    cla_lookahead #(.W(N_GRP)) u_level2 (
        .gen_i      (grp_gen_o),
        .prop_i     (grp_prop_o),
        .cin_i      (carry_i),
        .carry_o    (grp_carry),
        .grp_prop_o (blk_prop_o),
        .grp_gen_o  (blk_gen_o)
    );

    // carry out of the block is the last second-level carry
    assign carry_o = grp_carry[N_GRP];

    // whole-block result must match plain arithmetic
    always_comb begin
        AST_BLOCK_SUM: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, carry_i})); // R2
        AST_BLOCK_PROP: assert (blk_prop_o == (&(a_i | b_i))); // R7
    end
endmodule

// File: tb/sim_cla_adder16.sv
module sim_cla_adder16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NV         = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] a, b, sum;
    logic cin, cout, bp, bg;
    logic [3:0] gp, gg;
    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    // fields: {a, b, cin, expected sum, expected cout}
    localparam logic [49:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
        {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
        {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
        {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},
        {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0},
        {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0},
        {16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
        {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0},
        {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1},
        {16'h00FF, 16'h00FF, 1'b0, 16'h01FE, 1'b0}
    };

    cla_adder16 u0 (
        .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum), .carry_o(cout),
        .grp_prop_o(gp), .grp_gen_o(gg), .blk_prop_o(bp), .blk_gen_o(bg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cycles <= 0;
        else cycles <= cycles + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
        end
    endtask

    // apply one vector, then compare every output against arithmetic
    task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
        logic [16:0] full, nocin;
        @(posedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
        full  = {1'b0, va} + {1'b0, vb} + {16'b0, vc};
        nocin = {1'b0, va} + {1'b0, vb};
        chk("R1", {16'b0, sum}, {16'b0, full[15:0]});
        chk("R2", {31'b0, cout}, {31'b0, full[16]});
        for (int k = 0; k < 4; k++) begin
            logic [4:0] ns;
            ns = {1'b0, va[4*k +: 4]} + {1'b0, vb[4*k +: 4]};
            chk("R4", {31'b0, gp[k]}, {31'b0, &(va[4*k +: 4] | vb[4*k +: 4])});
            chk("R5", {31'b0, gg[k]}, {31'b0, ns[4]});
        end
        chk("R6", {31'b0, bg}, {31'b0, nocin[16]});
        chk("R7", {31'b0, bp}, {31'b0, &(va | vb)});
        chk("R8", {31'b0, cout}, {31'b0, bg | (bp & vc)});
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // table of directed vectors with literal expected results (R1, R2, R9)
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            a = VEC[i][49:34]; b = VEC[i][33:18]; cin = VEC[i][17];
            @(negedge clk);
            chk("R1", {16'b0, sum}, {16'b0, VEC[i][16:1]});
            chk("R9", {31'b0, cout}, {31'b0, VEC[i][0]});
        end
        // full-propagate chain crossing every group (R9)
        apply(16'hFFFF, 16'h0000, 1'b1);
        chk("R9", {16'b0, sum}, 32'h0);
        apply(16'hF0F0, 16'h0F0F, 1'b1);
        chk("R9", {31'b0, cout}, 32'h1);
        // dense sweep on the low byte, cin toggled (R1 R2 R3 R4 R5)
        for (int i = 0; i < 128; i++)
            for (int j = 0; j < 128; j++)
                apply(16'(i), 16'(j), 1'((i ^ j) & 1));
        // sweep across the boundary between groups 1 and 2 (R6 R7 R8)
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                apply(16'((i << 6) | 16'h0C3F), 16'((j << 6) | 16'h00C1), 1'(j & 1));
        done = 1'b1;
    end

    initial begin
        wait (done || cycles > WATCHDOG);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule